// File: doc/BRIEF.md
# Dual Parity Bus Transceiver with Error-Flag Latch

This block joins two byte-wide buses, called side A and side B, and carries a ninth parity bit alongside side B. It holds two independent slices. Each slice has its own pair of active-low output enables, which pick one of four modes:

- **A toward B:** the A byte is driven onto B unchanged, together with a freshly generated odd-parity bit.
- **B toward A:** the B byte is driven onto A unchanged, and the nine received bits (byte plus parity) are checked.
- **Diagnostic:** both enables are asserted. Data still flows from A to B, but the generated parity is inverted, so a downstream checker sees a forced error.
- **Isolation:** neither bus is driven.

Tri-state pins are modelled as separate input, output and drive-enable signals.

The result of the parity check feeds a per-slice error flag held in a clocked latch model. While the pass input is high, the live check result appears at the error output in the same cycle. Each rising clock edge that sees the pass input high samples that result. While the pass input is low, the output holds the last sample. A clear input forces the no-error state at once and empties the stored flag at the next edge, and it wins over the pass input.

The error output is active low and behaves like an open-collector pin: low means error, high means released. The check is applied only in the B-toward-A mode. In every other mode the check result counts as no error.

Top module: `tpar_xcvr`

## Requirements
- R1: With `oe_b_n` low, a slice drives `b_out` equal to `a_in` (no inversion) with `b_drive` and `par_drive` high in the same cycle; `a_drive` stays low.
- R2: With only `oe_b_n` low, `par_out` is 1 exactly when `a_in` has an even number of ones, so the nine bits on B carry an odd count of ones.
- R3: With both `oe_a_n` and `oe_b_n` low, data flows A to B as in R1 but `par_out` is inverted, so the nine B bits carry an even count of ones.
- R4: With only `oe_a_n` low, a slice drives `a_out` equal to `b_in` with `a_drive` high; `b_drive` and `par_drive` stay low.
- R5: In the mode of R4, with `latch_pass` high and `flag_clr` low, `err_n` is 0 when `b_in` plus `par_in` hold an even count of ones and 1 when the count is odd, in the same cycle.
- R6: With both enables high, `a_drive`, `b_drive` and `par_drive` are all low.
- R7: Outside the mode of R4, the check result is no-error: with `latch_pass` high, `err_n` is 1 whatever `b_in` and `par_in` carry.
- R8: With `latch_pass` low and `flag_clr` low, `err_n` shows the flag sampled at the last rising edge that saw `latch_pass` high (or cleared since), and it ignores changes on `b_in` and `par_in`.
- R9: `flag_clr` high forces `err_n` to 1 in the same cycle, over `latch_pass`. At the rising edge it empties the stored flag, so a following cycle with `latch_pass` low shows 1.
- R10: Synchronous `rst` empties the stored flag of every slice at the rising edge.
- R11: The slices are independent; each uses only its own enables, pass, clear, data and parity bits (slice i occupies data bits 8i+7..8i).

Clear having priority over pass, and flag bit 0 of the error output meaning error, both come from the requirements above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error-flag storage |
| rst | input | 1 | Synchronous active-high reset of the stored flags |
| oe_a_n | input | 2 | Per-slice active-low enable toward side A |
| oe_b_n | input | 2 | Per-slice active-low enable toward side B |
| latch_pass | input | 2 | Per-slice flag pass/sample control, high = transparent |
| flag_clr | input | 2 | Per-slice flag clear, high = clear |
| a_in | input | 16 | Side A bytes as seen on the pins |
| a_out | output | 16 | Side A bytes to drive |
| a_drive | output | 2 | Per-slice side A drive enable |
| b_in | input | 16 | Side B bytes as seen on the pins |
| b_out | output | 16 | Side B bytes to drive |
| b_drive | output | 2 | Per-slice side B drive enable |
| par_in | input | 2 | Per-slice received parity bit |
| par_out | output | 2 | Per-slice generated parity bit |
| par_drive | output | 2 | Per-slice parity pin drive enable |
| err_n | output | 2 | Per-slice active-low error flag, open-collector style |

## Verification
All data, parity and drive-enable results are combinational, so they are due in the same cycle as the enables and data that cause them. The error flag has two timings. It is live in the same cycle while passing or clearing. While holding, it shows what the previous rising edge captured, and a reset or clear takes effect from the edge onward. The bench applies each stimulus 1 ns after a rising edge and compares at the following falling edge. Its flag model advances its stored copy only at the step boundary that stands for that edge, so each expected value is tied to the right cycle.

// File: rtl/tpar_pkg.sv
package tpar_pkg;

    // Transfer mode, decoded from the two active-low enables {oe_a_n, oe_b_n}
    typedef enum logic [1:0] {
        MODE_DIAG    = 2'b00,  // both asserted: A to B, inverted parity
        MODE_B2A     = 2'b01,  // only A-side enable asserted
        MODE_A2B     = 2'b10,  // only B-side enable asserted
        MODE_ISOLATE = 2'b11   // neither asserted
    } xfer_mode_e;

    // Per-slice datapath controls derived from the mode
    typedef struct packed {
        logic drive_a;
        logic drive_b;
        logic invert_par;
        logic check_en;
    } path_ctl_t;

    // Per-slice flag controls
    typedef struct packed {
        logic pass;
        logic clr;
    } flag_ctl_t;

    function automatic xfer_mode_e decode_mode(input logic oe_a_n, input logic oe_b_n);
        return xfer_mode_e'({oe_a_n, oe_b_n});
    endfunction

    function automatic path_ctl_t mode_to_ctl(input xfer_mode_e m);
        path_ctl_t c;
        c = '0;
        unique case (m)
            MODE_A2B: begin
                c.drive_b = 1'b1;
            end
            MODE_DIAG: begin
                c.drive_b    = 1'b1;
                c.invert_par = 1'b1;
            end
            MODE_B2A: begin
                c.drive_a  = 1'b1;
                c.check_en = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tpar_mode_dec.sv
module tpar_mode_dec
    import tpar_pkg::*;
(
    input  logic      oe_a_n,
    input  logic      oe_b_n,
    output path_ctl_t ctl
);

    xfer_mode_e mode;

    always_comb begin
        mode = decode_mode(oe_a_n, oe_b_n);
        ctl  = mode_to_ctl(mode);
    end

endmodule

// File: rtl/tpar_parity_unit.sv
module tpar_parity_unit #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] gen_data,
    input  logic              invert,
    input  logic [DATA_W-1:0] chk_data,
    input  logic              chk_par,
    input  logic              chk_en,
    output logic              gen_par,
    output logic              live_err
);

    logic odd_bit;
    logic rx_ones_odd;

    always_comb begin
        // bit that makes data plus parity an odd count of ones
        odd_bit     = ~(^gen_data);
        gen_par     = odd_bit ^ invert;
        rx_ones_odd = ^{chk_data, chk_par};
        live_err    = chk_en & ~rx_ones_odd;
    end

endmodule

// File: rtl/tpar_err_latch.sv
module tpar_err_latch
    import tpar_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_ctl_t fctl,
    input  logic      live_err,
    output logic      err_flag
);

    logic held_q;

    always_ff @(posedge clk) begin
        if (rst || fctl.clr) begin
            held_q <= 1'b0;
        end else if (fctl.pass) begin
            held_q <= live_err;
        end
    end

    always_comb begin
        if (fctl.clr) begin
            err_flag = 1'b0;
        end else if (fctl.pass) begin
            err_flag = live_err;
        end else begin
            err_flag = held_q;
        end
    end

endmodule

// File: rtl/tpar_slice.sv
module tpar_slice
    import tpar_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  flag_ctl_t         fctl,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drive,
    input  logic              par_in,
    output logic              par_out,
    output logic              par_drive,
    output logic              err_n
);

    path_ctl_t ctl;
    logic      gen_par;
    logic      live_err;
    logic      err_flag;

    tpar_mode_dec u_dec (
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .ctl    (ctl)
    );

    tpar_parity_unit #(.DATA_W(DATA_W)) u_par (
        .gen_data (a_in),
        .invert   (ctl.invert_par),
        .chk_data (b_in),
        .chk_par  (par_in),
        .chk_en   (ctl.check_en),
        .gen_par  (gen_par),
        .live_err (live_err)
    );

    tpar_err_latch u_flag (
        .clk      (clk),
        .rst      (rst),
        .fctl     (fctl),
        .live_err (live_err),
        .err_flag (err_flag)
    );

    always_comb begin
        a_drive   = ctl.drive_a;
        b_drive   = ctl.drive_b;
        par_drive = ctl.drive_b;
        a_out     = ctl.drive_a ? b_in : '0;
        b_out     = ctl.drive_b ? a_in : '0;
        par_out   = ctl.drive_b ? gen_par : 1'b0;
        err_n     = ~err_flag;  // released high, pulled low on error
    end

endmodule

// File: rtl/tpar_xcvr.sv
module tpar_xcvr
    import tpar_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    parameter int DATA_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SLICES-1:0]        oe_a_n,
    input  logic [NUM_SLICES-1:0]        oe_b_n,
    input  logic [NUM_SLICES-1:0]        latch_pass,
    input  logic [NUM_SLICES-1:0]        flag_clr,
    input  logic [NUM_SLICES*DATA_W-1:0] a_in,
    output logic [NUM_SLICES*DATA_W-1:0] a_out,
    output logic [NUM_SLICES-1:0]        a_drive,
    input  logic [NUM_SLICES*DATA_W-1:0] b_in,
    output logic [NUM_SLICES*DATA_W-1:0] b_out,
    output logic [NUM_SLICES-1:0]        b_drive,
    input  logic [NUM_SLICES-1:0]        par_in,
    output logic [NUM_SLICES-1:0]        par_out,
    output logic [NUM_SLICES-1:0]        par_drive,
    output logic [NUM_SLICES-1:0]        err_n
);

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        localparam int LO = s * DATA_W;
        flag_ctl_t fctl;

        always_comb begin
            fctl.pass = latch_pass[s];
            fctl.clr  = flag_clr[s];
        end

        tpar_slice #(.DATA_W(DATA_W)) u_slice (
            .clk       (clk),
            .rst       (rst),
            .oe_a_n    (oe_a_n[s]),
            .oe_b_n    (oe_b_n[s]),
            .fctl      (fctl),
            .a_in      (a_in[LO +: DATA_W]),
            .a_out     (a_out[LO +: DATA_W]),
            .a_drive   (a_drive[s]),
            .b_in      (b_in[LO +: DATA_W]),
            .b_out     (b_out[LO +: DATA_W]),
            .b_drive   (b_drive[s]),
            .par_in    (par_in[s]),
            .par_out   (par_out[s]),
            .par_drive (par_drive[s]),
            .err_n     (err_n[s])
        );
    end

endmodule

// File: rtl/tpar_xcvr_chk.sv
module tpar_xcvr_chk #(
    parameter int NUM_SLICES = 2,
    parameter int DATA_W     = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_SLICES-1:0]        oe_a_n,
    input logic [NUM_SLICES-1:0]        oe_b_n,
    input logic [NUM_SLICES-1:0]        latch_pass,
    input logic [NUM_SLICES-1:0]        flag_clr,
    input logic [NUM_SLICES*DATA_W-1:0] a_in,
    input logic [NUM_SLICES*DATA_W-1:0] a_out,
    input logic [NUM_SLICES-1:0]        a_drive,
    input logic [NUM_SLICES*DATA_W-1:0] b_in,
    input logic [NUM_SLICES*DATA_W-1:0] b_out,
    input logic [NUM_SLICES-1:0]        b_drive,
    input logic [NUM_SLICES-1:0]        par_in,
    input logic [NUM_SLICES-1:0]        par_out,
    input logic [NUM_SLICES-1:0]        par_drive,
    input logic [NUM_SLICES-1:0]        err_n
);

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_chk
        localparam int LO = s * DATA_W;

        assert_a2b_data_R1: assert property (@(posedge clk) disable iff (rst)
            !oe_b_n[s] |-> (b_drive[s] && par_drive[s] && !a_drive[s]
                            && b_out[LO +: DATA_W] == a_in[LO +: DATA_W]));

        assert_odd_parity_R2: assert property (@(posedge clk) disable iff (rst)
            (!oe_b_n[s] && oe_a_n[s]) |-> (^{b_out[LO +: DATA_W], par_out[s]}));

        assert_diag_parity_R3: assert property (@(posedge clk) disable iff (rst)
            (!oe_b_n[s] && !oe_a_n[s]) |-> !(^{b_out[LO +: DATA_W], par_out[s]}));

        assert_b2a_data_R4: assert property (@(posedge clk) disable iff (rst)
            (!oe_a_n[s] && oe_b_n[s]) |-> (a_drive[s] && !b_drive[s] && !par_drive[s]
                            && a_out[LO +: DATA_W] == b_in[LO +: DATA_W]));

        assert_check_R5: assert property (@(posedge clk) disable iff (rst)
            (!oe_a_n[s] && oe_b_n[s] && latch_pass[s] && !flag_clr[s])
                |-> (err_n[s] == ^{b_in[LO +: DATA_W], par_in[s]}));

        assert_isolate_R6: assert property (@(posedge clk) disable iff (rst)
            (oe_a_n[s] && oe_b_n[s]) |-> (!a_drive[s] && !b_drive[s] && !par_drive[s]));

        assert_no_check_R7: assert property (@(posedge clk) disable iff (rst)
            (latch_pass[s] && !(!oe_a_n[s] && oe_b_n[s])) |-> err_n[s]);

        assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (!latch_pass[s] && !flag_clr[s] && !$past(rst)
             && $past(!latch_pass[s] && !flag_clr[s])) |-> $stable(err_n[s]));

        assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
            flag_clr[s] |-> err_n[s]);

        assert_clear_after_R9: assert property (@(posedge clk) disable iff (rst)
            (flag_clr[s] && !$past(rst)) |=> (latch_pass[s] || flag_clr[s] || err_n[s]));
    end

endmodule

bind tpar_xcvr tpar_xcvr_chk #(.NUM_SLICES(NUM_SLICES), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .latch_pass (latch_pass),
    .flag_clr   (flag_clr),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_drive    (a_drive),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_drive    (b_drive),
    .par_in     (par_in),
    .par_out    (par_out),
    .par_drive  (par_drive),
    .err_n      (err_n)
);

// File: tb/test_tpar_xcvr.sv
module test_tpar_xcvr;

    localparam int NS = 2;
    localparam int W  = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic [NS-1:0]   oe_a_n, oe_b_n, latch_pass, flag_clr, par_in;
    logic [NS*W-1:0] a_in, b_in;
    logic [NS*W-1:0] a_out, b_out;
    logic [NS-1:0]   a_drive, b_drive, par_out, par_drive, err_n;

    always #4 clk = ~clk;  // 125 MHz

    tpar_xcvr #(.NUM_SLICES(NS), .DATA_W(W)) i_tpar_xcvr (
        .clk(clk), .rst(rst), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .latch_pass(latch_pass), .flag_clr(flag_clr),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .par_in(par_in), .par_out(par_out), .par_drive(par_drive), .err_n(err_n)
    );

    typedef struct {
        logic [NS*W-1:0] a_out;
        logic [NS*W-1:0] b_out;
        logic [NS-1:0]   a_drv;
        logic [NS-1:0]   b_drv;
        logic [NS-1:0]   par;
        logic [NS-1:0]   err_n;
        string           tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [NS-1:0] held_m = '0;
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;

    // Driver: apply one cycle of stimulus and push what the requirements predict
    task automatic step(input logic r, input logic [NS-1:0] oa, input logic [NS-1:0] ob,
                        input logic [NS-1:0] ps, input logic [NS-1:0] cl,
                        input logic [NS*W-1:0] a, input logic [NS*W-1:0] b,
                        input logic [NS-1:0] p, input string tag);
        exp_t e;
        logic [NS-1:0] nxt;
        @(posedge clk);
        #1;
        rst = r; oe_a_n = oa; oe_b_n = ob; latch_pass = ps; flag_clr = cl;
        a_in = a; b_in = b; par_in = p;
        e.tag = tag;
        e.a_out = '0; e.b_out = '0;
        for (int s = 0; s < NS; s++) begin
            logic b2a, diag, live, flag;
            b2a  = !oa[s] && ob[s];
            diag = !oa[s] && !ob[s];
            e.b_drv[s] = !ob[s];
            e.a_drv[s] = b2a;
            e.b_out[s*W +: W] = a[s*W +: W];
            e.a_out[s*W +: W] = b[s*W +: W];
            e.par[s] = (~(^a[s*W +: W])) ^ diag;
            live = b2a && !(^{b[s*W +: W], p[s]});
            flag = cl[s] ? 1'b0 : (ps[s] ? live : held_m[s]);
            e.err_n[s] = !flag;
            nxt[s] = (r || cl[s]) ? 1'b0 : (ps[s] ? live : held_m[s]);
        end
        held_m = nxt;
        sb_q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what, input logic [NS*W-1:0] act,
                       input logic [NS*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare at the falling edge of the cycle the stimulus went in
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.tag, "a_drive", {{(NS*W-NS){1'b0}}, a_drive}, {{(NS*W-NS){1'b0}}, e.a_drv});
            cmp(e.tag, "b_drive", {{(NS*W-NS){1'b0}}, b_drive}, {{(NS*W-NS){1'b0}}, e.b_drv});
            cmp(e.tag, "par_drive", {{(NS*W-NS){1'b0}}, par_drive}, {{(NS*W-NS){1'b0}}, e.b_drv});
            cmp(e.tag, "err_n", {{(NS*W-NS){1'b0}}, err_n}, {{(NS*W-NS){1'b0}}, e.err_n});
            for (int s = 0; s < NS; s++) begin
                if (e.b_drv[s]) begin
                    cmp(e.tag, "b_out", {{(NS*W-W){1'b0}}, b_out[s*W +: W]},
                        {{(NS*W-W){1'b0}}, e.b_out[s*W +: W]});
                    cmp(e.tag, "par_out", {{(NS*W-1){1'b0}}, par_out[s]},
                        {{(NS*W-1){1'b0}}, e.par[s]});
                end
                if (e.a_drv[s])
                    cmp(e.tag, "a_out", {{(NS*W-W){1'b0}}, a_out[s*W +: W]},
                        {{(NS*W-W){1'b0}}, e.a_out[s*W +: W]});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; oe_a_n = '1; oe_b_n = '1; latch_pass = '0; flag_clr = '0;
        a_in = '0; b_in = '0; par_in = '0;

        // R10 reset state: isolated, flag empty
        step(1, 2'b11, 2'b11, 2'b00, 2'b11, 16'h0, 16'h0, 2'b00, "R10 reset with clear");
        step(1, 2'b11, 2'b11, 2'b00, 2'b00, 16'h0, 16'h0, 2'b00, "R10 reset hold");
        step(0, 2'b11, 2'b11, 2'b00, 2'b00, 16'h0, 16'h0, 2'b00, "R10 after reset");

        // R1 R2 A to B with several parity cases
        step(0, 2'b11, 2'b00, 2'b11, 2'b00, 16'h0100, 16'h0, 2'b00, "R1 R2 a2b 00/01");
        step(0, 2'b11, 2'b00, 2'b11, 2'b00, 16'hA5FF, 16'h0, 2'b00, "R1 R2 a2b ff/a5");
        step(0, 2'b11, 2'b00, 2'b11, 2'b00, 16'h8007, 16'h0, 2'b00, "R1 R2 a2b 07/80");
        // R7 A to B ignores a bad-looking B side
        step(0, 2'b11, 2'b00, 2'b11, 2'b00, 16'h1234, 16'h0000, 2'b00, "R7 no check a2b");

        // R3 diagnostic inverted parity
        step(0, 2'b00, 2'b00, 2'b11, 2'b00, 16'h00FF, 16'h0, 2'b00, "R3 diag");
        step(0, 2'b00, 2'b00, 2'b11, 2'b00, 16'h3C81, 16'h0, 2'b00, "R3 diag 2");

        // R6 isolation, R7 no check there
        step(0, 2'b11, 2'b11, 2'b11, 2'b00, 16'hFFFF, 16'h0000, 2'b00, "R6 R7 isolate");

        // R4 R5 B to A good and bad parity
        step(0, 2'b00, 2'b11, 2'b11, 2'b00, 16'h0, 16'h0000, 2'b11, "R4 R5 good");
        step(0, 2'b00, 2'b11, 2'b11, 2'b00, 16'h0, 16'h0301, 2'b11, "R4 R5 bad");
        step(0, 2'b00, 2'b11, 2'b11, 2'b00, 16'h0, 16'hFE7F, 2'b10, "R4 R5 mixed");

        // R8 capture error then hold while B becomes clean
        step(0, 2'b00, 2'b11, 2'b11, 2'b00, 16'h0, 16'h0000, 2'b00, "R5 capture err");
        step(0, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0, 16'h0000, 2'b11, "R8 hold err");
        step(0, 2'b11, 2'b00, 2'b00, 2'b00, 16'h0, 16'h0000, 2'b11, "R8 hold across mode");

        // R9 clear while holding, then hold shows cleared
        step(0, 2'b00, 2'b11, 2'b00, 2'b01, 16'h0, 16'h0000, 2'b00, "R9 clear slice0");
        step(0, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0, 16'h0000, 2'b00, "R9 R11 after clear");
        // R9 clear beats pass on a bad word
        step(0, 2'b00, 2'b11, 2'b11, 2'b11, 16'h0, 16'h0000, 2'b00, "R9 clear over pass");
        step(0, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0, 16'h0000, 2'b00, "R9 stored empty");

        // R11 independence: slice0 B2A bad, slice1 A2B
        step(0, 2'b10, 2'b01, 2'b11, 2'b00, 16'h5A00, 16'h0011, 2'b00, "R11 mixed slices");
        step(0, 2'b10, 2'b01, 2'b00, 2'b00, 16'h5A00, 16'h0010, 2'b01, "R11 R8 hold mixed");

        // R10 reset mid-run empties a held error
        step(0, 2'b00, 2'b11, 2'b11, 2'b00, 16'h0, 16'h0000, 2'b00, "R10 load err");
        step(1, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0, 16'h0000, 2'b00, "R10 reset cycle");
        step(0, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0, 16'h0000, 2'b00, "R10 after mid reset");

        // Mixed random traffic over all modes
        for (int k = 0; k < 300; k++) begin
            step(0, 2'($urandom), 2'($urandom), 2'($urandom), 2'(($urandom % 5) == 0),
                 16'($urandom), 16'($urandom), 2'($urandom), "R1 R5 R8 R9 random");
        end

        @(posedge clk);
        #2;
        wait (sb_q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule